// File: doc/BRIEF.md
# Character Display Text Sequencer

This block drives the request port of a character-display write interface so that one fixed line of text appears on the display. It sits between two switches (reset and go, both debounced upstream) and an interface block that owns all display timing. Every request is paced by the interface's ready flag: the sequencer presents one request for a single cycle, and it presents the next only after ready has been seen high again.

After reset the sequencer first blanks the display with a clear instruction, then waits for go. A rising edge of go starts a single pass over a constant text string held in an internal table, one character per request, from index 0 upwards. When the last character has been handed over, the block raises done and stays silent until the next reset, whatever go does. A go edge that arrives while the clear is still waiting for the interface is remembered and honoured once the clear has gone out.

Top module: `lcd_name_seq`

## Requirements
- R1: While reset is high and in the first cycle after it is released, reqValid and done are both 0.
- R2: The first request after reset needs no go: it is an instruction (reqIsChar = 0) carrying the clear code 8'h01.
- R3: reqValid is 1 only in a cycle that directly follows a rising clock edge at which ready was 1; while ready stays 0 no request appears.
- R4: reqValid is never 1 in two consecutive cycles.
- R5: Without a rising edge of goIn no character request is presented; after the clear the port stays idle.
- R6: After a go edge the block presents exactly NameLen character requests (reqIsChar = 1), whose reqData values are the ASCII bytes of NameText in order; index 0 is the leftmost character of the string literal, held in bits [8*NameLen-1 -: 8].
- R7: done rises in the same cycle as the final character request and stays 1 until reset; it is 0 for every earlier request.
- R8: Once done is 1, no further request is presented and later go edges have no effect.
- R9: goIn is edge detected: holding it high, including a level that is already high when reset is released (counted as one edge), starts exactly one pass.
- R10: A go edge that occurs before the clear request has been presented is stored, and the character pass starts once the clear has been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| goIn | input | 1 | Debounced start switch |
| ready | input | 1 | Interface can accept a request |
| reqValid | output | 1 | One-cycle request strobe |
| reqIsChar | output | 1 | 1 = character data, 0 = instruction |
| reqData | output | 8 | Character byte or instruction code |
| done | output | 1 | Text fully handed over, sticky until reset |

## Verification
A wrong state register shows up at the port as a request of the wrong kind or at the wrong time: a character before go, a second clear, or traffic after done, each visible within one ready cycle of the fault. A wrong character index shows up as a misplaced or repeated byte in the recorded request stream, or as a request count that is off by one, and a miscounted last index moves the rise of done away from the final character. A lost go-pending flag leaves the port silent after the clear, which the bench sees within a few dozen cycles.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  // longest string that fits one display line
  localparam int MaxChars = 16;

  // instruction code that blanks the display
  localparam logic [7:0] ClearCode = 8'h01;

  typedef enum logic [1:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_SEND,
    ST_DONE
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clearLoad;
    logic charLoad;
  } seqStrobe_t;

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
  import lcd_seq_pkg::*;
#(
  parameter int NameLen = 11,
  parameter logic [8*MaxChars-1:0] NameText = "PIXEL ROBOT",
  localparam int IdxW = $clog2(NameLen + 1)
) (
  input  logic [IdxW-1:0] idx,
  output logic [7:0]      charOut
);

  logic [7:0] romTable [NameLen];

  // index 0 is the leftmost character of the literal
  for (genvar g = 0; g < NameLen; g++) begin : g_rom
    assign romTable[g] = NameText[(NameLen-1-g)*8 +: 8];
  end

  always_comb begin
    charOut = 8'h20;
    for (int i = 0; i < NameLen; i++) begin
      if (idx == IdxW'(i)) charOut = romTable[i];
    end
  end

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       goIn,
  input  logic       ready,
  input  logic       reqBusy,
  input  logic       lastIdx,
  output seqStrobe_t strobe,
  output logic       done
);

  seqState_t state, stateNext;
  logic goPrev;
  logic goPending;
  logic goRise;
  logic canIssue;
  logic startNow;

  assign goRise   = goIn & ~goPrev;
  assign canIssue = ready & ~reqBusy;
  assign startNow = goRise | goPending;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_CLEAR: begin
        if (canIssue) begin
          strobe.clearLoad = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (startNow) stateNext = ST_SEND;
      end
      ST_SEND: begin
        if (canIssue) begin
          strobe.charLoad = 1'b1;
          if (lastIdx) stateNext = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLEAR;
      goPrev    <= 1'b0;
      goPending <= 1'b0;
    end else begin
      state  <= stateNext;
      goPrev <= goIn;
      if (state == ST_CLEAR && goRise) goPending <= 1'b1;
      else if (state == ST_IDLE)       goPending <= 1'b0;
    end
  end

  assign done = (state == ST_DONE);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_pending_early_r10: assert property (@(posedge clk) disable iff (rst)
    goPending |-> (state == ST_CLEAR || state == ST_IDLE));

endmodule

// File: rtl/lcd_seq_datapath.sv
module lcd_seq_datapath
  import lcd_seq_pkg::*;
#(
  parameter int NameLen = 11,
  parameter logic [8*MaxChars-1:0] NameText = "PIXEL ROBOT",
  localparam int IdxW = $clog2(NameLen + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ready,
  input  seqStrobe_t strobe,
  output logic       lastIdx,
  output logic       reqValid,
  output logic       reqIsChar,
  output logic [7:0] reqData
);

  logic [IdxW-1:0] idx;
  logic [7:0]      romChar;

  lcd_seq_rom #(
    .NameLen (NameLen),
    .NameText(NameText)
  ) u_rom (
    .idx    (idx),
    .charOut(romChar)
  );

  assign lastIdx = (idx == IdxW'(NameLen - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      reqValid  <= 1'b0;
      reqIsChar <= 1'b0;
      reqData   <= '0;
    end else begin
      reqValid <= strobe.clearLoad | strobe.charLoad;
      if (strobe.clearLoad) begin
        reqIsChar <= 1'b0;
        reqData   <= ClearCode;
      end else if (strobe.charLoad) begin
        reqIsChar <= 1'b1;
        reqData   <= romChar;
        idx       <= idx + 1'b1;
      end
    end
  end

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> !reqValid);

  p_issue_on_ready_r3: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> $past(ready));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
    idx <= IdxW'(NameLen));

  p_clear_code_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqIsChar) |-> (reqData == ClearCode));

endmodule

// File: rtl/lcd_name_seq.sv
module lcd_name_seq
  import lcd_seq_pkg::*;
#(
  parameter int NameLen = 11,
  parameter logic [8*MaxChars-1:0] NameText = "PIXEL ROBOT"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       goIn,
  input  logic       ready,
  output logic       reqValid,
  output logic       reqIsChar,
  output logic [7:0] reqData,
  output logic       done
);

  seqStrobe_t strobe;
  logic       lastIdx;

  lcd_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .goIn   (goIn),
    .ready  (ready),
    .reqBusy(reqValid),
    .lastIdx(lastIdx),
    .strobe (strobe),
    .done   (done)
  );

  lcd_seq_datapath #(
    .NameLen (NameLen),
    .NameText(NameText)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .strobe   (strobe),
    .lastIdx  (lastIdx),
    .reqValid (reqValid),
    .reqIsChar(reqIsChar),
    .reqData  (reqData)
  );

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> !reqValid);

  initial begin
    p_len_ok_r6: assert (NameLen >= 1 && NameLen <= MaxChars);
  end

endmodule

// File: tb/tb_lcd_name_seq.sv
module tb_lcd_name_seq;

  localparam string ExpName = "PIXEL ROBOT";
  localparam int    NLen    = 11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       goIn = 1'b0;
  logic       ready;
  logic       reqValid;
  logic       reqIsChar;
  logic [7:0] reqData;
  logic       done;

  int checks = 0;
  int fails  = 0;
  int cycleCnt = 0;

  // interface model
  logic readyEn = 1'b0;
  int   busyLen = 4;
  int   busyCnt = 0;

  // request log
  int   reqCnt = 0;
  logic logIsChar [64];
  logic [7:0] logData [64];
  logic logDone [64];
  logic prevValid = 1'b0;
  logic lastReady = 1'b0;

  lcd_name_seq dut (
    .clk(clk), .rst(rst), .goIn(goIn), .ready(ready),
    .reqValid(reqValid), .reqIsChar(reqIsChar), .reqData(reqData), .done(done)
  );

  always #5 clk = ~clk;

  assign ready = readyEn && (busyCnt == 0);

  always @(posedge clk) begin
    if (rst)              busyCnt <= 0;
    else if (reqValid)    busyCnt <= busyLen;
    else if (busyCnt > 0) busyCnt <= busyCnt - 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // monitor at the falling edge
  always @(negedge clk) begin
    cycleCnt++;
    if (!rst) begin
      if (reqValid) begin
        check(lastReady, "R3 ready before request", int'(lastReady), 1);
        check(!prevValid, "R4 back-to-back request", int'(prevValid), 0);
        if (reqCnt < 64) begin
          logIsChar[reqCnt] = reqIsChar;
          logData[reqCnt]   = reqData;
          logDone[reqCnt]   = done;
        end
        reqCnt++;
      end
      prevValid = reqValid;
    end else begin
      prevValid = 1'b0;
    end
    lastReady = ready;
  end

  always @(posedge clk) begin
    if (cycleCnt > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycleCnt, 100000);
      printSummary();
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic goLevel);
    @(negedge clk);
    rst  = 1'b1;
    goIn = goLevel;
    waitCycles(3);
    reqCnt = 0;
    rst = 1'b0;
  endtask

  task automatic pulseGo();
    goIn = 1'b1;
    @(negedge clk);
    goIn = 1'b0;
  endtask

  // clear followed by the full name, done only on the last entry
  task automatic checkStream(input string req);
    check(reqCnt == NLen + 1, {req, " request count"}, reqCnt, NLen + 1);
    check(logIsChar[0] == 1'b0, {req, " clear is instruction"}, int'(logIsChar[0]), 0);
    check(logData[0] == 8'h01, {req, " clear code"}, int'(logData[0]), 1);
    for (int i = 0; i < NLen; i++) begin
      check(logIsChar[i+1] == 1'b1, "R6 char flag", int'(logIsChar[i+1]), 1);
      check(logData[i+1] == ExpName[i], "R6 char order", int'(logData[i+1]), int'(ExpName[i]));
      check(logDone[i+1] == (i == NLen - 1), "R7 done timing",
            int'(logDone[i+1]), int'(i == NLen - 1));
    end
  endtask

  task automatic t_reset_and_clear();
    readyEn = 1'b0;
    busyLen = 4;
    doReset(1'b0);
    check(reqValid == 1'b0, "R1 reqValid after reset", int'(reqValid), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    waitCycles(10);
    check(reqCnt == 0, "R3 no request while ready low", reqCnt, 0);
    readyEn = 1'b1;
    waitCycles(10);
    check(reqCnt == 1, "R2 single clear", reqCnt, 1);
    check(logIsChar[0] == 1'b0 && logData[0] == 8'h01, "R2 clear content",
          int'(logData[0]), 1);
    waitCycles(30);
    check(reqCnt == 1, "R5 idle without go", reqCnt, 1);
    check(done == 1'b0, "R5 done low while idle", int'(done), 0);
  endtask

  task automatic t_send_name();
    pulseGo();
    waitCycles(150);
    checkStream("R6");
    check(done == 1'b1, "R7 done after pass", int'(done), 1);
  endtask

  task automatic t_ignore_after_done();
    pulseGo();
    waitCycles(5);
    pulseGo();
    waitCycles(60);
    check(reqCnt == NLen + 1, "R8 nothing after done", reqCnt, NLen + 1);
    check(done == 1'b1, "R7 done stays high", int'(done), 1);
  endtask

  task automatic t_go_held();
    readyEn = 1'b1;
    doReset(1'b1);
    waitCycles(200);
    checkStream("R9");
    goIn = 1'b0;
    waitCycles(3);
    goIn = 1'b1;
    waitCycles(40);
    check(reqCnt == NLen + 1, "R9 held go counts once", reqCnt, NLen + 1);
    goIn = 1'b0;
  endtask

  task automatic t_early_go();
    readyEn = 1'b0;
    doReset(1'b0);
    waitCycles(2);
    pulseGo();
    waitCycles(8);
    check(reqCnt == 0, "R10 nothing before ready", reqCnt, 0);
    readyEn = 1'b1;
    waitCycles(200);
    checkStream("R10");
  endtask

  task automatic t_fast_ready();
    busyLen = 0;
    readyEn = 1'b1;
    doReset(1'b0);
    waitCycles(5);
    pulseGo();
    waitCycles(80);
    checkStream("R4");
    check(done == 1'b1, "R7 done with fast ready", int'(done), 1);
  endtask

  initial begin
    t_reset_and_clear();
    t_send_name();
    t_ignore_after_done();
    t_go_held();
    t_early_go();
    t_fast_ready();
    printSummary();
    $finish;
  end

endmodule